// File: doc/BRIEF.md
# Hypervisor Call Decision Sequencer

This block decides what happens when a guest-to-monitor call instruction is executed. A one-cycle `start` pulse samples a snapshot of processor context: the virtualization operation state, the execution mode, the privilege level, the prefix bits and the state of the monitor's system-management machinery. The block walks a fixed priority chain over that snapshot. The first check that matches sets the single outcome. Possible outcomes are an undefined-opcode fault, a general-protection fault, a guest exit, a monitor-mode exit, a flag-style failure, or activation of dual-monitor handling.

If every early check passes, the sequencer briefly enters system-management mode (`smm_hold`). It then reads two words through a valid/ready channel: first the monitor revision identifier, then the monitor feature word. It leaves that mode again at the end, whether a check failed or activation succeeded. Each evaluated instruction produces one `done` strobe lasting one cycle, carrying an outcome code and a 5-bit error number.

Top module: `hvc_seq`

## Requirements
- R1: After reset, `done`, `rd_valid`, `smm_hold` and `rd_sel` are 0, and `outcome` and `err_num` are 0.
- R2: Prefix bits 0 (lock), 1 (repeat) and 2 (operand size) of `pfx` raise an undefined-opcode outcome (code 1) before any other check is made. Bits 3 to 5 (segment, address size, register extension) have no effect on the outcome.
- R3: `op_state` 00 (outside) or 11 gives code 1. `op_state` 10 (non-root) gives guest exit (code 3).
- R4: With `op_state` 01 (root), `v86_mode`, or `long_mode` with `cs_64` low, gives code 1. Otherwise a nonzero `cpl` gives general-protection (code 2).
- R5: Next, `smm_active`, a low `dual_sup` or a low `mon_ctl_valid` gives a failure. If `ptr_valid` is high, the outcome is code 6 with error 1. If it is low, the outcome is code 5 with error 0.
- R6: Next, `dual_active` gives monitor-mode exit (code 4).
- R7: Next, a low `ptr_valid` gives code 5 with error 0. A low `launch_clear` gives code 6 with error 2. A low `exit_ctl_ok` gives code 6 with error 3. They are checked in that order.
- R8: When all earlier checks pass, `rd_valid` and `smm_hold` rise with `rd_sel`=0. They hold steady until `rd_ready`. A revision other than `REV_ID` ends with code 6, error 4, and `smm_hold` falls.
- R9: A matching revision is followed by a read with `rd_sel`=1. A feature word with any bit outside `FEAT_ALLOWED` ends with code 6, error 5. Otherwise the outcome is activation (code 7) with error 0.
- R10: `done` is high for one cycle per instruction. It rises one cycle after the deciding clock edge. `outcome` and `err_num` are 0 whenever `done` is low, and `err_num` is 0 for all codes except 6.
- R11: `start` is ignored while a read phase is in progress. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the instruction with the present context |
| pfx | input | 6 | Prefix presence bits |
| op_state | input | 2 | 00 outside, 01 root, 10 non-root |
| v86_mode | input | 1 | Virtual-8086 mode |
| long_mode | input | 1 | Long mode active |
| cs_64 | input | 1 | Code segment is 64-bit |
| cpl | input | 2 | Current privilege level |
| smm_active | input | 1 | Already in system-management mode |
| dual_sup | input | 1 | Dual-monitor treatment supported |
| mon_ctl_valid | input | 1 | Monitor-control valid bit |
| dual_active | input | 1 | Dual-monitor treatment already active |
| ptr_valid | input | 1 | Current control-structure pointer valid |
| launch_clear | input | 1 | Launch state is clear |
| exit_ctl_ok | input | 1 | Exit control fields valid |
| rd_valid | output | 1 | Read request |
| rd_sel | output | 1 | 0 revision word, 1 feature word |
| rd_ready | input | 1 | Read data present this cycle |
| rd_data | input | 32 | Read data |
| smm_hold | output | 1 | Temporary system-management mode |
| done | output | 1 | Outcome strobe |
| outcome | output | 3 | Outcome code |
| err_num | output | 5 | Error number |

## Verification
The `done` strobe of one instruction and the acceptance of the next `start` can fall in the same cycle. The bench holds `start` high across the strobe cycle of an immediately decided instruction and expects a second strobe in the following cycle. It also raises `start` during a read phase and checks that the phase still finishes with activation and that no extra strobe follows.

// File: rtl/hvc_pkg.sv
package hvc_pkg;
    localparam int ERR_W = 5;
    localparam int PFX_W = 6;
    // prefix bits 0..2 fault, 3..5 are tolerated
    localparam logic [PFX_W-1:0] PFX_FAULT_MASK = 6'b000111;

    localparam logic [1:0] OPS_OUTSIDE = 2'b00;
    localparam logic [1:0] OPS_ROOT    = 2'b01;
    localparam logic [1:0] OPS_NONROOT = 2'b10;

    typedef enum logic [2:0] {
        OUT_NONE       = 3'd0,
        OUT_UD         = 3'd1,
        OUT_GP         = 3'd2,
        OUT_GUEST_EXIT = 3'd3,
        OUT_MON_EXIT   = 3'd4,
        OUT_FAIL_NOPTR = 3'd5,
        OUT_FAIL_CODE  = 3'd6,
        OUT_ACTIVATE   = 3'd7
    } outcome_e;

    localparam logic [ERR_W-1:0] ERR_ROOT_CALL = 5'd1;
    localparam logic [ERR_W-1:0] ERR_NOT_CLEAR = 5'd2;
    localparam logic [ERR_W-1:0] ERR_EXIT_CTL  = 5'd3;
    localparam logic [ERR_W-1:0] ERR_REVISION  = 5'd4;
    localparam logic [ERR_W-1:0] ERR_FEATURES  = 5'd5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REV  = 2'd1,
        ST_RD_FEAT = 2'd2
    } state_e;

    typedef struct packed {
        state_e           state;
        logic             done;
        outcome_e         outcome;
        logic [ERR_W-1:0] err;
    } seq_st_t;
endpackage

// File: rtl/hvc_gate.sv
module hvc_gate
    import hvc_pkg::*;
(
    input  logic [PFX_W-1:0] pfx,
    input  logic [1:0]       op_state,
    input  logic             v86_mode,
    input  logic             long_mode,
    input  logic             cs_64,
    input  logic [1:0]       cpl,
    input  logic             smm_active,
    input  logic             dual_sup,
    input  logic             mon_ctl_valid,
    input  logic             dual_active,
    input  logic             ptr_valid,
    input  logic             launch_clear,
    input  logic             exit_ctl_ok,
    output logic             decided,
    output outcome_e         verdict,
    output logic [ERR_W-1:0] verdict_err
);
    logic pfx_fault;
    logic mode_fault;
    logic mon_unusable;

    assign pfx_fault    = |(pfx & PFX_FAULT_MASK);
    assign mode_fault   = v86_mode || (long_mode && !cs_64);
    assign mon_unusable = smm_active || !dual_sup || !mon_ctl_valid;

    always_comb begin
        decided     = 1'b1;
        verdict     = OUT_NONE;
        verdict_err = '0;
        if (pfx_fault) begin
            verdict = OUT_UD;
        end else if (op_state == OPS_NONROOT) begin
            verdict = OUT_GUEST_EXIT;
        end else if (op_state != OPS_ROOT) begin
            verdict = OUT_UD;
        end else if (mode_fault) begin
            verdict = OUT_UD;
        end else if (cpl != 2'd0) begin
            verdict = OUT_GP;
        end else if (mon_unusable) begin
            if (ptr_valid) begin
                verdict     = OUT_FAIL_CODE;
                verdict_err = ERR_ROOT_CALL;
            end else begin
                verdict = OUT_FAIL_NOPTR;
            end
        end else if (dual_active) begin
            verdict = OUT_MON_EXIT;
        end else if (!ptr_valid) begin
            verdict = OUT_FAIL_NOPTR;
        end else if (!launch_clear) begin
            verdict     = OUT_FAIL_CODE;
            verdict_err = ERR_NOT_CLEAR;
        end else if (!exit_ctl_ok) begin
            verdict     = OUT_FAIL_CODE;
            verdict_err = ERR_EXIT_CTL;
        end else begin
            decided = 1'b0;
        end
    end
endmodule

// File: rtl/hvc_field_check.sv
module hvc_field_check #(
    parameter int              DATA_W       = 32,
    parameter logic [DATA_W-1:0] REV_ID       = 32'h0000_0A17,
    parameter logic [DATA_W-1:0] FEAT_ALLOWED = 32'h0000_0007
) (
    input  logic [DATA_W-1:0] word,
    input  logic              is_feat,
    output logic              word_ok
);
    logic rev_match;
    logic feat_clean;

    assign rev_match  = (word == REV_ID);
    assign feat_clean = ((word & ~FEAT_ALLOWED) == '0);
    assign word_ok    = is_feat ? feat_clean : rev_match;
endmodule

// File: rtl/hvc_seq.sv
module hvc_seq
    import hvc_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter logic [DATA_W-1:0] REV_ID       = 32'h0000_0A17,
    parameter logic [DATA_W-1:0] FEAT_ALLOWED = 32'h0000_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        pfx,
    input  logic [1:0]        op_state,
    input  logic              v86_mode,
    input  logic              long_mode,
    input  logic              cs_64,
    input  logic [1:0]        cpl,
    input  logic              smm_active,
    input  logic              dual_sup,
    input  logic              mon_ctl_valid,
    input  logic              dual_active,
    input  logic              ptr_valid,
    input  logic              launch_clear,
    input  logic              exit_ctl_ok,
    output logic              rd_valid,
    output logic              rd_sel,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              smm_hold,
    output logic              done,
    output logic [2:0]        outcome,
    output logic [4:0]        err_num
);
    seq_st_t          st_d, st_q;
    logic             gate_decided;
    outcome_e         gate_verdict;
    logic [ERR_W-1:0] gate_err;
    logic             word_ok;
    logic             in_read;

    hvc_gate u_gate (
        .pfx          (pfx),
        .op_state     (op_state),
        .v86_mode     (v86_mode),
        .long_mode    (long_mode),
        .cs_64        (cs_64),
        .cpl          (cpl),
        .smm_active   (smm_active),
        .dual_sup     (dual_sup),
        .mon_ctl_valid(mon_ctl_valid),
        .dual_active  (dual_active),
        .ptr_valid    (ptr_valid),
        .launch_clear (launch_clear),
        .exit_ctl_ok  (exit_ctl_ok),
        .decided      (gate_decided),
        .verdict      (gate_verdict),
        .verdict_err  (gate_err)
    );

    hvc_field_check #(
        .DATA_W      (DATA_W),
        .REV_ID      (REV_ID),
        .FEAT_ALLOWED(FEAT_ALLOWED)
    ) u_field (
        .word   (rd_data),
        .is_feat(st_q.state == ST_RD_FEAT),
        .word_ok(word_ok)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.outcome = OUT_NONE;
        st_d.err     = '0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (gate_decided) begin
                        st_d.done    = 1'b1;
                        st_d.outcome = gate_verdict;
                        st_d.err     = gate_err;
                    end else begin
                        st_d.state = ST_RD_REV;
                    end
                end
            end
            ST_RD_REV: begin
                if (rd_ready) begin
                    if (word_ok) begin
                        st_d.state = ST_RD_FEAT;
                    end else begin
                        st_d.state   = ST_IDLE;
                        st_d.done    = 1'b1;
                        st_d.outcome = OUT_FAIL_CODE;
                        st_d.err     = ERR_REVISION;
                    end
                end
            end
            ST_RD_FEAT: begin
                if (rd_ready) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                    if (word_ok) begin
                        st_d.outcome = OUT_ACTIVATE;
                    end else begin
                        st_d.outcome = OUT_FAIL_CODE;
                        st_d.err     = ERR_FEATURES;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, done: 1'b0, outcome: OUT_NONE, err: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_read  = (st_q.state != ST_IDLE);
    assign rd_valid = in_read;
    assign smm_hold = in_read;
    assign rd_sel   = (st_q.state == ST_RD_FEAT);
    assign done     = st_q.done;
    assign outcome  = st_q.outcome;
    assign err_num  = st_q.err;
endmodule

// File: rtl/hvc_seq_chk.sv
module hvc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid,
    input logic       rd_sel,
    input logic       rd_ready,
    input logic       done,
    input logic [2:0] outcome,
    input logic [4:0] err_num
);
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (outcome == 3'd0 && err_num == 5'd0));

    assert_strobe_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> outcome != 3'd0);

    assert_err_only_on_code6_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome != 3'd6) |-> err_num == 5'd0);

    assert_code6_has_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == 3'd6) |-> err_num != 5'd0);

    assert_read_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_sel)));

    assert_rev_then_feat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_sel) |=> (done || (rd_valid && rd_sel)));

    assert_activate_after_feat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == 3'd7) |-> $past(rd_valid && rd_sel && rd_ready));
endmodule

bind hvc_seq hvc_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .rd_sel  (rd_sel),
    .rd_ready(rd_ready),
    .done    (done),
    .outcome (outcome),
    .err_num (err_num)
);

// File: tb/sim_hvc_seq.sv
module sim_hvc_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [5:0]  pfx;
    logic [1:0]  op_state;
    logic        v86_mode, long_mode, cs_64;
    logic [1:0]  cpl;
    logic        smm_active, dual_sup, mon_ctl_valid, dual_active;
    logic        ptr_valid, launch_clear, exit_ctl_ok;
    logic        rd_valid, rd_sel, rd_ready, smm_hold, done;
    logic [31:0] rd_data;
    logic [2:0]  outcome;
    logic [4:0]  err_num;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] REV_GOOD  = 32'h0000_0A17;
    localparam logic [31:0] FEAT_GOOD = 32'h0000_0005;
    localparam logic [31:0] FEAT_BAD  = 32'h0000_0010;

    always #5 clk = ~clk;

    hvc_seq u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_good();
        pfx = 6'd0; op_state = 2'b01; v86_mode = 0; long_mode = 1; cs_64 = 1; cpl = 0;
        smm_active = 0; dual_sup = 1; mon_ctl_valid = 1; dual_active = 0;
        ptr_valid = 1; launch_clear = 1; exit_ctl_ok = 1;
    endtask

    // pulse start; returns at the falling edge after the sampling edge
    task automatic fire();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic expect_out(input string req, input int code, input int err);
        chk(req, "done", done, 1);
        chk(req, "outcome", outcome, code);
        chk(req, "err_num", err_num, err);
        @(negedge clk);
        chk(req, "done one cycle (R10)", done, 0);
    endtask

    task automatic read_word(input logic [31:0] w);
        rd_ready = 1'b1; rd_data = w;
        @(negedge clk);
        rd_ready = 1'b0; rd_data = 32'hDEAD_BEEF;
    endtask

    task automatic t_reset();
        chk("R1", "done", done, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "smm_hold", smm_hold, 0);
        chk("R1", "rd_sel", rd_sel, 0);
        chk("R1", "outcome", outcome, 0);
        chk("R1", "err_num", err_num, 0);
    endtask

    task automatic t_prefix();
        for (int b = 0; b < 3; b++) begin
            set_good(); op_state = 2'b10; pfx = 6'd1 << b;
            fire(); expect_out("R2", 1, 0);
        end
        set_good(); dual_active = 1; pfx = 6'b111000;
        fire(); expect_out("R2 ignored prefixes", 4, 0);
    endtask

    task automatic t_opstate();
        set_good(); op_state = 2'b00; fire(); expect_out("R3", 1, 0);
        set_good(); op_state = 2'b11; fire(); expect_out("R3", 1, 0);
        set_good(); op_state = 2'b10; cpl = 3; fire(); expect_out("R3", 3, 0);
    endtask

    task automatic t_root_mode();
        set_good(); v86_mode = 1; fire(); expect_out("R4", 1, 0);
        set_good(); cs_64 = 0; cpl = 3; fire(); expect_out("R4", 1, 0);
        set_good(); long_mode = 0; cs_64 = 0; cpl = 3; fire(); expect_out("R4", 2, 0);
        set_good(); cpl = 1; fire(); expect_out("R4", 2, 0);
    endtask

    task automatic t_mon_unusable();
        set_good(); smm_active = 1; dual_active = 1; fire(); expect_out("R5", 6, 1);
        set_good(); dual_sup = 0; ptr_valid = 0; fire(); expect_out("R5", 5, 0);
        set_good(); mon_ctl_valid = 0; fire(); expect_out("R5", 6, 1);
    endtask

    task automatic t_mon_exit();
        set_good(); dual_active = 1; ptr_valid = 0; fire(); expect_out("R6", 4, 0);
    endtask

    task automatic t_pointer();
        set_good(); ptr_valid = 0; launch_clear = 0; fire(); expect_out("R7", 5, 0);
        set_good(); launch_clear = 0; exit_ctl_ok = 0; fire(); expect_out("R7", 6, 2);
        set_good(); exit_ctl_ok = 0; fire(); expect_out("R7", 6, 3);
    endtask

    task automatic t_rev_fail();
        set_good(); fire();
        chk("R8", "done", done, 0);
        for (int i = 0; i < 2; i++) begin
            chk("R8", "rd_valid stall", rd_valid, 1);
            chk("R8", "smm_hold stall", smm_hold, 1);
            chk("R8", "rd_sel stall", rd_sel, 0);
            @(negedge clk);
        end
        read_word(REV_GOOD ^ 32'h1);
        chk("R8", "smm_hold after fail", smm_hold, 0);
        chk("R8", "rd_valid after fail", rd_valid, 0);
        expect_out("R8", 6, 4);
    endtask

    task automatic t_feat();
        set_good(); fire();
        read_word(REV_GOOD);
        chk("R9", "rd_sel", rd_sel, 1);
        chk("R9", "rd_valid", rd_valid, 1);
        chk("R9", "done", done, 0);
        read_word(FEAT_BAD);
        chk("R9", "smm_hold after fail", smm_hold, 0);
        expect_out("R9", 6, 5);
        set_good(); fire();
        read_word(REV_GOOD);
        read_word(FEAT_GOOD);
        chk("R9", "smm_hold after activate", smm_hold, 0);
        expect_out("R9", 7, 0);
    endtask

    task automatic t_overlap();
        // start during the read phase is ignored
        set_good(); fire();
        op_state = 2'b00;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R11", "no strobe from busy start", done, 0);
        chk("R11", "still reading", rd_valid, 1);
        read_word(REV_GOOD);
        read_word(FEAT_GOOD);
        expect_out("R11", 7, 0);
        chk("R11", "no late strobe", done, 0);
        // start held across the strobe cycle is accepted again
        set_good(); cpl = 2;
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        chk("R11", "first strobe", done, 1);
        chk("R11", "first code", outcome, 2);
        @(negedge clk) start = 1'b0;
        chk("R11", "second strobe", done, 1);
        chk("R11", "second code", outcome, 2);
        @(negedge clk);
        chk("R11", "strobes end", done, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; rd_ready = 1'b0; rd_data = '0;
        set_good();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefix();
        t_opstate();
        t_root_mode();
        t_mon_unusable();
        t_mon_exit();
        t_pointer();
        t_rev_fail();
        t_feat();
        t_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule